// File: doc/BRIEF.md
# Serial-Load Latched Display Driver Core

This block is the logic core of a multi-output display driver. A host shifts display bits in one at a time on a serial data line, clocked by a slow serial clock. A serial output carries the bit that falls off the far end of the chain, so several drivers can be daisy-chained. A strobe edge copies the whole shift chain into a holding register in one step. The held bits are what the outputs show, so a new frame can be loaded without disturbing the current one.

Two level inputs override the held data. The enable input blanks every output while it is low. The force input turns every output on while enable is high. Both of these inputs default to 0, so a driver that is left unconfigured shows nothing.

The serial clock, serial data and strobe arrive without any timing relation to the system clock. The block synchronizes them through flop chains and acts on the rising edges it detects. If the serial clock rises while the strobe is held high, the block clears the shift chain and the holding register together. A host uses this to reach a known state at power-up.

Top module: `disp_serial_driver`

## Requirements
- R1: Each detected rising edge of `ser_clk_i` (with `strobe_i` low) moves every shift stage k to stage k+1 and loads the synchronized `ser_dat_i` into stage 0. After N such edges, the first bit entered sits in stage N-1 and the last bit entered sits in stage 0.
- R2: `chain_o` always equals shift stage N-1.
- R3: A detected rising edge of `strobe_i` copies shift stage k into holding bit k for every k. At all other times, apart from R4, the holding register keeps its value, including while new bits are shifted in.
- R4: A detected rising edge of `ser_clk_i` while the synchronized `strobe_i` is high clears every shift stage and every holding bit to 0. This takes priority over shifting and over a strobe load.
- R5: While `enable_i` is 0, every bit of `drive_o` is 0, whatever `force_i` and the holding register hold.
- R6: While `enable_i` is 1 and `force_i` is 1, every bit of `drive_o` is 1.
- R7: While `enable_i` is 1 and `force_i` is 0, `drive_o[k]` equals holding bit k.
- R8: An asynchronous low level on `rst_ni` clears the shift chain, the holding register and the synchronizer state, so `chain_o` is 0 and a later pass-through shows all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous to clk_i |
| ser_dat_i | input | 1 | Serial display data, held stable around ser_clk_i rising |
| strobe_i | input | 1 | Latch strobe, asynchronous to clk_i |
| enable_i | input | 1 | Output enable; 0 blanks all outputs |
| force_i | input | 1 | All-on test when enable_i is 1 |
| chain_o | output | 1 | Last shift stage, for cascading |
| drive_o | output | N | Per-output drive levels |

## Verification
A single 1 followed by zeros checks the direction of the shift chain and the mapping of stages to outputs, which a reversed index would break. A mixed pattern is first loaded and then replaced in the chain before any strobe. This separates a held register from one that follows the chain, and the serial output is checked after every bit. The all-on and blanking combinations are each applied over non-trivial held data, so the priority between the two controls shows up. A serial clock edge with the strobe high is followed by a fresh strobe. The outputs then show whether the clear reached the chain as well as the holding register.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    OUT_BLANK  = 2'd0,
    OUT_ALL_ON = 2'd1,
    OUT_DATA   = 2'd2
  } out_mode_e;

  function automatic out_mode_e decode_mode(input logic en, input logic frc);
    if (!en)     return OUT_BLANK;
    else if (frc) return OUT_ALL_ON;
    else         return OUT_DATA;
  endfunction
endpackage

// File: rtl/disp_edge_sync.sv
module disp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/disp_shift_chain.sv
module disp_shift_chain #(
  parameter int N = 60
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clear_i,
  input  logic         dat_i,
  output logic [N-1:0] stage_o
);
  logic [N-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clear_i) sr_q <= '0;
    else if (step_i)  sr_q <= {sr_q[N-2:0], dat_i};
  end

  assign stage_o = sr_q;
endmodule

// File: rtl/disp_hold_reg.sv
module disp_hold_reg #(
  parameter int N = 60
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (clear_i) q_q <= '0;
    else if (load_i)  q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/disp_out_sel.sv
module disp_out_sel
  import disp_pkg::*;
#(
  parameter int N = 60
) (
  input  logic         enable_i,
  input  logic         force_i,
  input  logic [N-1:0] hold_i,
  output logic [N-1:0] drive_o
);
  out_mode_e mode;

  assign mode = decode_mode(enable_i, force_i);

  for (genvar k = 0; k < N; k++) begin : g_out
    always_comb begin
      unique case (mode)
        OUT_ALL_ON: drive_o[k] = 1'b1;
        OUT_DATA:   drive_o[k] = hold_i[k];
        default:    drive_o[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/disp_serial_driver.sv
module disp_serial_driver #(
  parameter int N         = 60,
  parameter int SYNC_STGS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_clk_i,
  input  logic         ser_dat_i,
  input  logic         strobe_i,
  input  logic         enable_i,
  input  logic         force_i,
  output logic         chain_o,
  output logic [N-1:0] drive_o
);
  logic sck_lvl, sck_rise, stb_lvl, stb_rise, dat_lvl, dat_rise;
  logic clr, step, load;
  logic [N-1:0] stages, hold;

  disp_edge_sync #(.STAGES(SYNC_STGS)) i_sck_sync (
    .clk_i, .rst_ni, .async_i(ser_clk_i), .level_o(sck_lvl), .rise_o(sck_rise)
  );
  disp_edge_sync #(.STAGES(SYNC_STGS)) i_stb_sync (
    .clk_i, .rst_ni, .async_i(strobe_i), .level_o(stb_lvl), .rise_o(stb_rise)
  );
  // data follows the same latency as the clock so it is taken at the detected edge
  disp_edge_sync #(.STAGES(SYNC_STGS)) i_dat_sync (
    .clk_i, .rst_ni, .async_i(ser_dat_i), .level_o(dat_lvl), .rise_o(dat_rise)
  );

  assign clr  = sck_rise & stb_lvl;
  assign step = sck_rise & ~stb_lvl;
  assign load = stb_rise;

  disp_shift_chain #(.N(N)) i_chain (
    .clk_i, .rst_ni, .step_i(step), .clear_i(clr), .dat_i(dat_lvl), .stage_o(stages)
  );

  disp_hold_reg #(.N(N)) i_hold (
    .clk_i, .rst_ni, .load_i(load), .clear_i(clr), .d_i(stages), .q_o(hold)
  );

  disp_out_sel #(.N(N)) i_out (
    .enable_i, .force_i, .hold_i(hold), .drive_o
  );

  assign chain_o = stages[N-1];

  logic unused_dat_rise;
  assign unused_dat_rise = dat_rise & sck_lvl;
endmodule

// File: rtl/disp_serial_driver_chk.sv
module disp_serial_driver_chk #(
  parameter int N = 60
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         enable_i,
  input logic         force_i,
  input logic         sck_rise,
  input logic         stb_lvl,
  input logic         stb_rise,
  input logic [N-1:0] stages,
  input logic [N-1:0] hold,
  input logic         chain_o,
  input logic [N-1:0] drive_o
);
  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && !stb_lvl) |=> stages[N-1:1] == $past(stages[N-2:0]));

  p_chain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o == stages[N-1]);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_rise && !(sck_rise && stb_lvl)) |=> hold == $past(stages));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_rise && !sck_rise) |=> $stable(hold));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && stb_lvl) |=> (stages == '0 && hold == '0));

  p_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> drive_o == '0);

  p_all_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && force_i) |-> drive_o == '1);

  p_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !force_i) |-> drive_o == hold);
endmodule

bind disp_serial_driver disp_serial_driver_chk #(.N(N)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .force_i(force_i),
  .sck_rise(sck_rise), .stb_lvl(stb_lvl), .stb_rise(stb_rise),
  .stages(stages), .hold(hold), .chain_o(chain_o), .drive_o(drive_o)
);

// File: tb/test_disp_serial_driver.sv
`timescale 1ns/1ps
module test_disp_serial_driver;
  localparam int N = 60;
  localparam int SETTLE = 6;

  typedef struct {
    string        tag;
    logic [N-1:0] drv;
    logic         chn;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, strobe = 1'b0, enable = 1'b0, frc = 1'b0;
  logic chain;
  logic [N-1:0] drive;

  logic [N-1:0] m_sr = '0, m_hold = '0;
  exp_t exp_q[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_serial_driver #(.N(N)) i_disp_serial_driver (
    .clk_i(clk), .rst_ni(rst_ni), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .strobe_i(strobe), .enable_i(enable), .force_i(frc),
    .chain_o(chain), .drive_o(drive)
  );

  function automatic logic [N-1:0] model_out();
    if (!enable) return '0;
    if (frc)     return '1;
    return m_hold;
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    @(negedge clk);
    e.tag = tag; e.drv = model_out(); e.chn = m_sr[N-1];
    exp_q.push_back(e);
    -> chk_ev;
    wait_clks(1);
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b;
    wait_clks(SETTLE);
    ser_clk = 1'b1;
    if (strobe) begin m_sr = '0; m_hold = '0; end
    else m_sr = {m_sr[N-2:0], b};
    wait_clks(SETTLE);
    ser_clk = 1'b0;
    wait_clks(SETTLE);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    m_hold = m_sr;
    wait_clks(SETTLE);
    strobe = 1'b0;
    wait_clks(SETTLE);
  endtask

  task automatic set_ctl(input logic en, input logic f);
    enable = en; frc = f;
    wait_clks(1);
  endtask

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (drive !== e.drv || chain !== e.chn) begin
          n_fail++;
          $display("FAIL %s: drive=%h chain=%b expected drive=%h chain=%b",
                   e.tag, drive, chain, e.drv, e.chn);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    wait_clks(3);
    expect_now("R8 reset held, blanked");
    rst_ni = 1'b1;
    wait_clks(2);
    set_ctl(1'b1, 1'b0);
    expect_now("R8 reset state passes zeros");

    // single one entered first lands on the last output
    ser_bit(1'b1);
    for (int i = 1; i < N; i++) ser_bit(1'b0);
    expect_now("R1 R2 walking one at last stage");
    pulse_strobe();
    expect_now("R1 R3 R7 walking one ordering");

    // mixed pattern, chain checked per bit, hold unchanged until strobe
    for (int i = 0; i < N; i++) begin
      ser_bit(((i % 3) == 0) || (i == 7));
      expect_now("R2 R3 chain per bit, hold kept");
    end
    pulse_strobe();
    expect_now("R3 R7 mixed pattern loaded");

    set_ctl(1'b1, 1'b1);
    expect_now("R6 all on over data");
    set_ctl(1'b0, 1'b1);
    expect_now("R5 blank over force");
    set_ctl(1'b0, 1'b0);
    expect_now("R5 blank plain");
    set_ctl(1'b1, 1'b0);
    expect_now("R7 data restored");

    // alternating pattern, then clear via serial clock under strobe
    for (int i = 0; i < N; i++) ser_bit(i[0]);
    pulse_strobe();
    expect_now("R7 alternating pattern");
    strobe = 1'b1;
    m_hold = m_sr;
    wait_clks(SETTLE);
    ser_bit(1'b1);
    strobe = 1'b0;
    wait_clks(SETTLE);
    expect_now("R4 clear of hold and chain");
    pulse_strobe();
    expect_now("R4 chain cleared before reload");

    // asynchronous reset mid-frame
    for (int i = 0; i < 5; i++) ser_bit(1'b1);
    rst_ni = 1'b0;
    m_sr = '0; m_hold = '0;
    wait_clks(2);
    rst_ni = 1'b1;
    wait_clks(2);
    expect_now("R8 reset mid-frame");

    wait_clks(2);
    done = 1'b1;
    finish_run();
  end
endmodule